// File: doc/BRIEF.md
# Line Interface Serial Register Master

This block drives the bit-serial control port of a line interface device. A host pulses `start` and supplies three things: a read/write flag, a 4-bit register address and, for a write, a value. The block then asserts the select line and clocks out a 16-bit frame, least significant bit first.

The first half of the frame is always sent by the master. It carries a direction bit and a 7-bit address field. The address field holds the 4 real address bits and then zero padding. In the second half, a write sends an 8-bit data field that holds 5 significant bits. A read instead samples 8 bits from the device.

When the frame ends, the block parks the serial clock low, drops the select line, pulses `done` and, for a read, presents the assembled byte. The serial clock half-period is the parameter `HALF_CYC`, counted in system clocks.

Top module: `lif_ser_master`

## Requirements
- R1: After reset, `cs`, `sclk`, `sdo`, `busy` and `done` are low and `rd_data` is 0.
- R2: Frame bit 0 (the first bit sent) is 1 for a read and 0 for a write.
- R3: Frame bits 1..4 carry `reg_addr[0]`..`reg_addr[3]` in that order, and bits 5..7 are zero.
- R4: On a write, frame bits 8..12 carry `wr_val[0]`..`wr_val[4]` and bits 13..15 are zero. `wr_val[7:5]` has no effect on the frame. On a read, `sdo` stays 0 during bits 8..15.
- R5: On a read, `sdi` is sampled during the high phase of frame bits 8..15. The bit sampled in frame bit 8+k lands in `rd_data[k]`.
- R6: Each frame has exactly 16 `sclk` pulses. Each high phase lasts `HALF_CYC` system clocks. `sdo` is set up while `sclk` is low and holds steady while `sclk` is high, and `sclk` is high only while `cs` is high.
- R7: After the last pulse, `sclk` stays low for a trailing phase. Then `cs` falls, `busy` falls and `done` is high for exactly one cycle, all in the same cycle.
- R8: `rd_data` changes only in a cycle where `done` is high at the end of a read. A write leaves it unchanged.
- R9: A `start` pulse while `busy` is high is ignored: the running frame and its single `done` are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| rd_req | input | 1 | 1 = read, 0 = write |
| reg_addr | input | 4 | Device register address |
| wr_val | input | 8 | Write value; only bits 4..0 are used |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rd_data | output | 8 | Last read result |
| sclk | output | 1 | Serial clock |
| cs | output | 1 | Device select, active high |
| sdo | output | 1 | Serial data to device |
| sdi | input | 1 | Serial data from device |

## Verification
The hardest case to reach from the ports is a start request that arrives in the middle of a frame. The bench raises `start` with different flag, address and value inputs partway through a frame. It then confirms that the captured frame, the sampled read data and the single `done` all match the original request.

A device model in the bench captures `sdo` on rising `sclk` edges. It drives `sdi` from a falling-edge bit counter, so each read bit is in place before the high phase in which it is sampled. The bench sweeps all addresses with every 5-bit write value, each carrying nonzero upper bits, and a spread of read patterns.

// File: rtl/lif_ser_master.sv
module lif_ser_master #(
  parameter int HALF_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rd_req,
  input  logic [3:0] reg_addr,
  input  logic [7:0] wr_val,
  output logic       busy,
  output logic       done,
  output logic [7:0] rd_data,
  output logic       sclk,
  output logic       cs,
  output logic       sdo,
  input  logic       sdi
);
  localparam int FRAME = 16;
  localparam int BW    = $clog2(FRAME);
  localparam int TW    = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_END} st_t;

  st_t              st;
  logic [TW-1:0]    tmr;
  logic [BW-1:0]    bidx;
  logic [FRAME-1:0] tx;
  logic [7:0]       rx;
  logic             is_rd;

  wire phase_end = (tmr == TW'(HALF_CYC - 1));
  wire last_bit  = (bidx == BW'(FRAME - 1));

  assign busy = (st != S_IDLE);
  assign sdo  = tx[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tmr     <= '0;
      bidx    <= '0;
      tx      <= '0;
      rx      <= '0;
      is_rd   <= 1'b0;
      sclk    <= 1'b0;
      cs      <= 1'b0;
      done    <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            st    <= S_LO;
            tmr   <= '0;
            bidx  <= '0;
            is_rd <= rd_req;
            cs    <= 1'b1;
            tx    <= {3'b000, rd_req ? 5'b0 : wr_val[4:0], 3'b000, reg_addr, rd_req};
          end
        end
        S_LO: begin
          if (phase_end) begin
            tmr  <= '0;
            sclk <= 1'b1;
            st   <= S_HI;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_HI: begin
          if (phase_end) begin
            tmr  <= '0;
            sclk <= 1'b0;
            if (is_rd && bidx[BW-1]) rx <= {sdi, rx[7:1]};
            if (last_bit) begin
              st <= S_END;
              tx <= '0;
            end else begin
              bidx <= bidx + 1'b1;
              tx   <= {1'b0, tx[FRAME-1:1]};
              st   <= S_LO;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_END: begin
          if (phase_end) begin
            tmr  <= '0;
            cs   <= 1'b0;
            done <= 1'b1;
            st   <= S_IDLE;
            if (is_rd) rd_data <= rx;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lif_ser_master_chk.sv
module lif_ser_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       busy,
  input logic       sclk,
  input logic       cs,
  input logic       sdo,
  input logic [7:0] rd_data
);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_cs_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs) |-> (done && !sclk && !busy));
  a_r6_sclk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> cs);
  a_r6_sdo_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdo));
  a_r8_rd_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> done);
endmodule

bind lif_ser_master lif_ser_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .busy(busy), .sclk(sclk),
  .cs(cs), .sdo(sdo), .rd_data(rd_data)
);

// File: tb/test_lif_ser_master.sv
module test_lif_ser_master;
  localparam int HALF = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rd_req = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] wr_val = '0;
  logic busy, done, sclk, cs, sdo, sdi;
  logic [7:0] rd_data;

  int vectors = 0, fails = 0, cyc = 0;
  int pcnt = 0, ncnt = 0, hcnt = 0;
  logic [15:0] cap = '0;
  logic [7:0] pat = '0;
  logic [7:0] last_rd = '0;

  always #2.5 clk = ~clk;

  lif_ser_master #(.HALF_CYC(HALF)) i_lif_ser_master (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req),
    .reg_addr(reg_addr), .wr_val(wr_val), .busy(busy), .done(done),
    .rd_data(rd_data), .sclk(sclk), .cs(cs), .sdo(sdo), .sdi(sdi));

  always @(posedge sclk) begin
    if (pcnt < 16) cap[pcnt] <= sdo;
    pcnt <= pcnt + 1;
  end
  always @(negedge sclk) ncnt <= ncnt + 1;
  always @(posedge clk) if (sclk) hcnt <= hcnt + 1;
  assign sdi = (cs && ncnt >= 8 && ncnt < 16) ? pat[ncnt[2:0]] : 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog R7: actual no completion, expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors = vectors + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input logic rd, input logic [3:0] a, input logic [7:0] v,
                     input logic [7:0] p, input bit intrude);
    logic [15:0] exp;
    int n;
    int dones;
    pcnt = 0; ncnt = 0; hcnt = 0; pat = p;
    @(negedge clk);
    rd_req = rd; reg_addr = a; wr_val = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0; dones = 0;
    if (intrude) begin
      repeat (20) @(negedge clk);
      rd_req = ~rd; reg_addr = ~a; wr_val = ~v; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && n < 400) begin
      @(negedge clk);
      n = n + 1;
    end
    chk("R7 done seen", int'(done), 1);
    chk("R7 cs low at done", int'(cs), 0);
    chk("R7 sclk low at done", int'(sclk), 0);
    chk("R7 busy low at done", int'(busy), 0);
    exp = {3'b000, rd ? 5'b0 : v[4:0], 3'b000, a, rd};
    chk("R2 direction bit", int'(cap[0]), int'(rd));
    chk("R3 address field", int'(cap[7:1]), int'({3'b000, a}));
    chk(rd ? "R4 read data phase sdo" : "R4 write data field", int'(cap[15:8]), int'(exp[15:8]));
    chk("R6 pulse count", pcnt, 16);
    chk("R6 high time", hcnt, 16 * HALF);
    if (rd) begin
      chk(intrude ? "R9 read data" : "R5 read data", int'(rd_data), int'(p));
      last_rd = p;
    end else begin
      chk("R8 write keeps rd_data", int'(rd_data), int'(last_rd));
    end
    @(negedge clk);
    chk("R7 done one cycle", int'(done), 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (done) dones = dones + 1;
    end
    chk(intrude ? "R9 no second frame" : "R7 idle after", dones + int'(busy) + int'(cs), 0);
    chk("R8 rd_data held", int'(rd_data), int'(last_rd));
  endtask

  initial begin
    #1;
    chk("R1 cs", int'(cs), 0);
    chk("R1 sclk", int'(sclk), 0);
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 sdo", int'(sdo), 0);
    rst_n = 1'b1;
    for (int a = 0; a < 16; a++)
      for (int v = 0; v < 32; v++)
        run(1'b0, 4'(a), {3'((a * 5 + v) | 1), 5'(v)}, 8'h00, 1'b0);
    for (int a = 0; a < 16; a++)
      for (int k = 0; k < 16; k++)
        run(1'b1, 4'(a), 8'hFF, 8'(a * 29 + k * 53 + 1), 1'b0);
    run(1'b1, 4'h3, 8'h00, 8'h00, 1'b0);
    run(1'b1, 4'hC, 8'h00, 8'hFF, 1'b0);
    run(1'b0, 4'hA, 8'hF5, 8'h00, 1'b0);
    run(1'b1, 4'h6, 8'h00, 8'hA5, 1'b1);
    run(1'b0, 4'h9, 8'h13, 8'h00, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule